// File: doc/BRIEF.md
# Cluster Responder Detect and Address Encoder

This unit sits between a cluster controller and a 16 by 16 grid of bit-serial processing elements. Each element raises a single response bit. The unit collapses those 256 bits onto one shared any-responder line and onto one active-low wired-OR line per row and per column. From these lines it reports three things: whether anything responded, which rows and which columns hold a responder, and the exact position of the lowest-numbered responder. Element index r*16+c is bit r*16+c of the response vector, so row r occupies bits r*16 through r*16+15.

The same row and column lines also work in the other direction. When the controller drives them, either with a pair of masks or with one encoded address, they pick out a block of elements or a single element for conditional execution. The resulting per-element select vector is an output of the unit. A separate counting engine takes a snapshot of the response bits into a shift chain and clocks it through an accumulator one bit per cycle. This gives the number of responders without an adder tree that is 256 bits wide.

Top module: `cluster_resp_unit`

## Requirements
- R1: `any_o` is 1 exactly when at least one bit of `resp_i` was 1 at the previous clock edge. It follows the responses in every select mode.
- R2: In element-driven mode (`sel_mode_i` = 0 or 3), `row_mask_o[r]` is 1 exactly when some bit `resp_i[r*16+c]` was 1, and `col_mask_o[c]` is 1 exactly when some bit `resp_i[r*16+c]` was 1. All outputs are registered, one cycle after the inputs.
- R3: In element-driven mode, `first_addr_o` = {`first_row_o`, `first_col_o`} is the lowest index i with `resp_i[i]` = 1, with the row in bits 7:4 and the column in bits 3:0. When there is no responder, all three outputs are 0.
- R4: In mask mode (`sel_mode_i` = 1), `sel_o[r*16+c]` = `row_sel_i[r]` AND `col_sel_i[c]`. The mask outputs echo the driven masks. `first_row_o` and `first_col_o` are the lowest set bits of those masks, or 0 if a mask is empty.
- R5: In address mode (`sel_mode_i` = 2), exactly one bit of `sel_o` is set, the bit at index `addr_sel_i`. The row mask and column mask each have one bit set, and `first_addr_o` equals `addr_sel_i`.
- R6: In element-driven mode, every bit of `sel_o` is 1, so execution is unconditional.
- R7: When `count_start_i` is sampled high while the counter is idle, the unit captures `resp_i`. `count_done_o` is then high for exactly one cycle, after the 256th following clock edge. At that point `count_o` equals the number of ones in the captured vector (0 to 256), and it holds that value until the next count completes.
- R8: During a count, changes on `resp_i` do not alter the result, and a start pulse during a count is ignored. No extra done pulse follows.
- R9: During reset all outputs are 0, including `sel_o` and `count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_i | input | 256 | Response bit of each element, index row*16+col |
| sel_mode_i | input | 2 | 0/3 element-driven, 1 mask select, 2 address select |
| row_sel_i | input | 16 | Row mask driven in mask mode |
| col_sel_i | input | 16 | Column mask driven in mask mode |
| addr_sel_i | input | 8 | Encoded element address driven in address mode |
| count_start_i | input | 1 | Starts a responder count |
| any_o | output | 1 | Some element is responding |
| row_mask_o | output | 16 | Active rows on the row lines |
| col_mask_o | output | 16 | Active columns on the column lines |
| first_row_o | output | 4 | Row of the first responder or selection |
| first_col_o | output | 4 | Column of the first responder or selection |
| first_addr_o | output | 8 | Linear address row*16+col of the first responder |
| sel_o | output | 256 | Per-element select for conditional execution |
| count_o | output | 9 | Last completed responder count |
| count_done_o | output | 1 | One-cycle pulse when a count completes |

## Verification
A fault in the detect path shows at the ports in the very next cycle. A wrongly mapped row or column line moves a bit in a mask or shifts `first_addr_o`. A priority encoder that scans in the wrong direction reports the highest responder rather than the lowest, so the tests use several responders spread across rows and within one row. A fault in the shift chain or the accumulator stays hidden for the whole count. It shows only when the count completes: `count_done_o` arrives a cycle early or late, or `count_o` is wrong. For that reason the bench checks every cycle of the window for an early done and checks the end values at 0, at 256 and at a mixed pattern.

// File: rtl/crd_pkg.sv
package crd_pkg;

    typedef enum logic [1:0] {
        MODE_ELEM  = 2'd0,
        MODE_MASK  = 2'd1,
        MODE_ADDR  = 2'd2,
        MODE_ELEM2 = 2'd3
    } sel_mode_e;

endpackage

// File: rtl/crd_line_gather.sv
module crd_line_gather #(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic [ROWS*COLS-1:0] resp,
    output logic [ROWS-1:0]      row_line_n,
    output logic [COLS-1:0]      col_line_n
);
    // Each line is pulled low when any element on it responds.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_line_n[r] = ~(|resp[r*COLS +: COLS]);
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                hit = hit | resp[r*COLS + c];
            end
        end
        assign col_line_n[c] = ~hit;
    end
endmodule

// File: rtl/crd_prio_enc.sv
module crd_prio_enc #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          hit
);
    // Scan downward so the lowest set bit wins; index 0 when empty.
    always_comb begin
        idx = '0;
        for (int i = W-1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        hit = |vec;
    end
endmodule

// File: rtl/crd_shift_count.sv
module crd_shift_count #(
    parameter int N    = 256,
    localparam int SW  = $clog2(N),
    localparam int CNW = $clog2(N+1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   bits,
    output logic [CNW-1:0] count,
    output logic           done
);
    typedef struct packed {
        logic [N-1:0]   chain;
        logic [CNW-1:0] acc;
        logic [SW-1:0]  step;
        logic           busy;
        logic           done;
        logic [CNW-1:0] count;
    } cnt_state_t;

    cnt_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.acc   = s_q.acc + CNW'(s_q.chain[0]);
            s_d.chain = s_q.chain >> 1;
            s_d.step  = s_q.step + 1'b1;
            if (s_q.step == SW'(N-1)) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.count = s_q.acc + CNW'(s_q.chain[0]);
            end
        end else if (start) begin
            s_d.chain = bits;
            s_d.acc   = '0;
            s_d.step  = '0;
            s_d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.count;
    assign done  = s_q.done;
endmodule

// File: rtl/cluster_resp_unit.sv
module cluster_resp_unit #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int N   = ROWS*COLS,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int AW  = RW + CW,
    localparam int CNW = $clog2(N+1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   resp_i,
    input  logic [1:0]     sel_mode_i,
    input  logic [ROWS-1:0] row_sel_i,
    input  logic [COLS-1:0] col_sel_i,
    input  logic [AW-1:0]  addr_sel_i,
    input  logic           count_start_i,
    output logic           any_o,
    output logic [ROWS-1:0] row_mask_o,
    output logic [COLS-1:0] col_mask_o,
    output logic [RW-1:0]  first_row_o,
    output logic [CW-1:0]  first_col_o,
    output logic [AW-1:0]  first_addr_o,
    output logic [N-1:0]   sel_o,
    output logic [CNW-1:0] count_o,
    output logic           count_done_o
);
    import crd_pkg::*;

    typedef struct packed {
        logic            any;
        logic [ROWS-1:0] rmask;
        logic [COLS-1:0] cmask;
        logic [RW-1:0]   frow;
        logic [CW-1:0]   fcol;
        logic [N-1:0]    sel;
    } det_state_t;

    det_state_t d_q, d_d;

    logic [ROWS-1:0] elem_row_n, row_line_n, row_act;
    logic [COLS-1:0] elem_col_n, col_line_n, col_act, col_scan;
    logic [RW-1:0]   frow;
    logic [CW-1:0]   fcol;
    logic            row_hit, col_hit;
    sel_mode_e       mode;

    assign mode = sel_mode_e'(sel_mode_i);

    crd_line_gather #(.ROWS(ROWS), .COLS(COLS)) gather_i (
        .resp       (resp_i),
        .row_line_n (elem_row_n),
        .col_line_n (elem_col_n)
    );

    // Line ownership: elements drive unless the controller selects.
    always_comb begin
        row_line_n = elem_row_n;
        col_line_n = elem_col_n;
        case (mode)
            MODE_MASK: begin
                row_line_n = ~row_sel_i;
                col_line_n = ~col_sel_i;
            end
            MODE_ADDR: begin
                row_line_n = ~(ROWS'(1) << addr_sel_i[AW-1:CW]);
                col_line_n = ~(COLS'(1) << addr_sel_i[CW-1:0]);
            end
            default: ;
        endcase
        row_act = ~row_line_n;
        col_act = ~col_line_n;
    end

    crd_prio_enc #(.W(ROWS)) row_enc_i (
        .vec (row_act),
        .idx (frow),
        .hit (row_hit)
    );

    // Column scan is restricted to the first active row when elements drive,
    // so the pair names the true lowest linear address.
    always_comb begin
        col_scan = col_act;
        if (mode == MODE_ELEM || mode == MODE_ELEM2) begin
            for (int c = 0; c < COLS; c++) begin
                col_scan[c] = resp_i[int'(frow)*COLS + c];
            end
        end
    end

    crd_prio_enc #(.W(COLS)) col_enc_i (
        .vec (col_scan),
        .idx (fcol),
        .hit (col_hit)
    );

    always_comb begin
        d_d       = d_q;
        d_d.any   = |resp_i;
        d_d.rmask = row_act;
        d_d.cmask = col_act;
        d_d.frow  = row_hit ? frow : '0;
        d_d.fcol  = col_hit ? fcol : '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (mode == MODE_ELEM || mode == MODE_ELEM2)
                    d_d.sel[r*COLS + c] = 1'b1;
                else
                    d_d.sel[r*COLS + c] = row_act[r] & col_act[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    crd_shift_count #(.N(N)) counter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (count_start_i),
        .bits  (resp_i),
        .count (count_o),
        .done  (count_done_o)
    );

    assign any_o        = d_q.any;
    assign row_mask_o   = d_q.rmask;
    assign col_mask_o   = d_q.cmask;
    assign first_row_o  = d_q.frow;
    assign first_col_o  = d_q.fcol;
    assign first_addr_o = {d_q.frow, d_q.fcol};
    assign sel_o        = d_q.sel;
endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int N   = ROWS*COLS,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int AW  = RW + CW,
    localparam int CNW = $clog2(N+1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    resp_i,
    input logic [1:0]      sel_mode_i,
    input logic [ROWS-1:0] row_sel_i,
    input logic [AW-1:0]   addr_sel_i,
    input logic            any_o,
    input logic [ROWS-1:0] row_mask_o,
    input logic [RW-1:0]   first_row_o,
    input logic [AW-1:0]   first_addr_o,
    input logic [N-1:0]    sel_o,
    input logic [CNW-1:0]  count_o,
    input logic            count_done_o
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r1_any_follows: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> any_o == $past(|resp_i));

    a_r3_first_row_active: assert property (@(posedge clk) disable iff (!rst_n)
        (row_mask_o != '0) |-> row_mask_o[first_row_o]);

    a_r4_mask_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(sel_mode_i) == 2'd1) |-> row_mask_o == $past(row_sel_i));

    a_r5_addr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(sel_mode_i) == 2'd2) |->
            ($countones(sel_o) == 1 && first_addr_o == $past(addr_sel_i)));

    a_r6_elem_all_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(sel_mode_i) == 2'd0 || $past(sel_mode_i) == 2'd3)) |-> (&sel_o));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        count_done_o |=> !count_done_o);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNW'(N));
endmodule

bind cluster_resp_unit crd_checker #(.ROWS(ROWS), .COLS(COLS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .resp_i       (resp_i),
    .sel_mode_i   (sel_mode_i),
    .row_sel_i    (row_sel_i),
    .addr_sel_i   (addr_sel_i),
    .any_o        (any_o),
    .row_mask_o   (row_mask_o),
    .first_row_o  (first_row_o),
    .first_addr_o (first_addr_o),
    .sel_o        (sel_o),
    .count_o      (count_o),
    .count_done_o (count_done_o)
);

// File: tb/cluster_resp_unit_tb_top.sv
module cluster_resp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 16;
    localparam int COLS = 16;
    localparam int N    = ROWS*COLS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  resp = '0;
    logic [1:0]    mode = 2'd0;
    logic [15:0]   rsel = '0;
    logic [15:0]   csel = '0;
    logic [7:0]    asel = '0;
    logic          start = 1'b0;

    logic          any_o, count_done_o;
    logic [15:0]   row_mask_o, col_mask_o;
    logic [3:0]    first_row_o, first_col_o;
    logic [7:0]    first_addr_o;
    logic [N-1:0]  sel_o;
    logic [8:0]    count_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cluster_resp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .resp_i(resp), .sel_mode_i(mode),
        .row_sel_i(rsel), .col_sel_i(csel), .addr_sel_i(asel),
        .count_start_i(start), .any_o(any_o), .row_mask_o(row_mask_o),
        .col_mask_o(col_mask_o), .first_row_o(first_row_o),
        .first_col_o(first_col_o), .first_addr_o(first_addr_o),
        .sel_o(sel_o), .count_o(count_o), .count_done_o(count_done_o)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [N-1:0] v);
        int n = 0;
        for (int i = 0; i < N; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [15:0] rows_of(input logic [N-1:0] v);
        logic [15:0] m = '0;
        for (int i = 0; i < N; i++) if (v[i]) m[i/COLS] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] cols_of(input logic [N-1:0] v);
        logic [15:0] m = '0;
        for (int i = 0; i < N; i++) if (v[i]) m[i%COLS] = 1'b1;
        return m;
    endfunction

    // R1 R2 R3 R6: element-driven detection
    task automatic t_elem(input logic [N-1:0] pat, input logic [1:0] m);
        int lo;
        @(negedge clk);
        resp = pat; mode = m;
        @(negedge clk);
        lo = lowest(pat);
        check("R1 any", N'(any_o), N'(|pat));
        check("R2 row mask", N'(row_mask_o), N'(rows_of(pat)));
        check("R2 col mask", N'(col_mask_o), N'(cols_of(pat)));
        check("R3 first addr", N'(first_addr_o), N'(lo));
        check("R3 first row", N'(first_row_o), N'(lo / COLS));
        check("R6 all selected", sel_o, {N{1'b1}});
    endtask

    // R4: mask selection
    task automatic t_mask(input logic [15:0] r, input logic [15:0] c);
        logic [N-1:0] exp = '0;
        @(negedge clk);
        mode = 2'd1; rsel = r; csel = c; resp = {N{1'b1}};
        for (int i = 0; i < N; i++) exp[i] = r[i/COLS] & c[i%COLS];
        @(negedge clk);
        check("R4 sel", sel_o, exp);
        check("R4 row echo", N'(row_mask_o), N'(r));
        check("R4 col echo", N'(col_mask_o), N'(c));
        check("R4 first addr", N'(first_addr_o),
              N'((r == 0 ? 0 : lowest(N'(r))) * COLS + (c == 0 ? 0 : lowest(N'(c)))));
        check("R1 any in mask mode", N'(any_o), N'(1));
    endtask

    // R5: address selection
    task automatic t_addr(input logic [7:0] a);
        logic [N-1:0] exp = '0;
        @(negedge clk);
        mode = 2'd2; asel = a; resp = '0;
        exp[a] = 1'b1;
        @(negedge clk);
        check("R5 sel onehot", sel_o, exp);
        check("R5 first addr", N'(first_addr_o), N'(a));
        check("R5 row mask", N'(row_mask_o), N'(16'(1) << a[7:4]));
        check("R5 col mask", N'(col_mask_o), N'(16'(1) << a[3:0]));
        check("R1 any quiet", N'(any_o), N'(0));
    endtask

    // R7 R8: shift-chain count
    task automatic t_count(input logic [N-1:0] pat);
        int early = 0;
        int prev;
        @(negedge clk);
        mode = 2'd0; resp = pat; start = 1'b1;
        @(negedge clk);
        start = 1'b0; resp = ~pat;
        prev = int'(count_o);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            if (i == 10) start = 1'b1;
            if (i == 11) start = 1'b0;
            if (i == 40) resp = '0;
            if (count_done_o) early++;
        end
        check("R7 no early done", N'(early), N'(0));
        check("R7 held count", N'(count_o), N'(prev));
        @(negedge clk);
        check("R7 done pulse", N'(count_done_o), N'(1));
        check("R8 count of snapshot", N'(count_o), N'(popc(pat)));
        @(negedge clk);
        check("R7 done single", N'(count_done_o), N'(0));
        check("R8 no second done", N'(count_o), N'(popc(pat)));
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (count_done_o) early++;
        end
        check("R8 ignored start", N'(early), N'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R7 watchdog act=hung exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] p;
        repeat (3) @(negedge clk);
        check("R9 reset any", N'(any_o), N'(0));
        check("R9 reset sel", sel_o, '0);
        check("R9 reset count", N'({count_o, count_done_o}), N'(0));
        check("R9 reset masks", N'({row_mask_o, col_mask_o, first_addr_o}), N'(0));
        rst_n = 1'b1;

        t_elem('0, 2'd0);
        p = '0; p[0] = 1'b1;        t_elem(p, 2'd0);
        p = '0; p[255] = 1'b1;      t_elem(p, 2'd0);
        p = '0; p[200] = 1'b1; p[39] = 1'b1; p[37] = 1'b1; t_elem(p, 2'd0);
        p = '0; p[47] = 1'b1; p[33] = 1'b1; p[130] = 1'b1; t_elem(p, 2'd3);

        t_mask(16'h0102, 16'h8010);
        t_mask(16'h0000, 16'hFFFF);
        t_addr(8'h00);
        t_addr(8'hFF);
        t_addr(8'h5A);

        t_count('0);
        t_count({N{1'b1}});
        p = '0;
        for (int i = 0; i < N; i += 3) p[i] = 1'b1;
        p[255] = 1'b1;
        t_count(p);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule